// File: doc/BRIEF.md
# SPI Register Slave with Busy Signalling

This block lets a host reach a small set of byte registers over a SPI mode-0 link. A transaction begins with one header byte. Bit 7 of that byte selects the direction and bits 6:0 give the register address. A write header is followed by one value byte. A read header causes the slave to return the addressed register in the next byte. The SPI pins are sampled in the system clock domain through a synchronizer chain, so SCLK must run several times slower than the system clock.

Some registers form the setup for a back-end operation. These are an address register, a data register, two 16-bit settings (drive and threshold, each split across two byte registers) and an 8-bit sense-delay value. Writing a command bit to the control register starts one of three back-end operations, each over a request/done handshake: a memory write, a memory read, or a potentiometer update. A memory operation can take a long time. While it is pending and chip select is high, the slave drives MISO high as a busy flag. The host polls that pin before it issues the next command or reads a memory result.

Top module: `spireg_slave`

## Requirements
- R1: SPI mode 0. MOSI is sampled on each rising SCLK edge, most significant bit first. MISO changes only after a rising edge. Transmit data is all zeros during the header byte.
- R2: A header with bit 7 set is a write. The second byte is stored into the register at address bits 6:0. Any byte after the second in the same chip-select window is ignored.
- R3: A header with bit 7 clear is a read. The addressed register value is shifted out MSB first in the following byte. Unmapped addresses 0x08 to 0x7F read 0x00. The control register also reads 0x00, because its bits are self-clearing.
- R4: The register map is as follows. 0x00 is the memory address. 0x01 is the memory data. 0x02 is the control register: bit0 memory read, bit1 memory write, bit2 pot update. 0x03 and 0x04 are drive high and low. 0x05 and 0x06 are threshold high and low. 0x07 is sense delay.
- R5: While CSn is high, MISO is 1 while a memory operation is pending and 0 otherwise. A pending pot update does not show as busy.
- R6: Control bit1 raises mem_req with mem_we=1. mem_addr and mem_wdata are copies of the address and data registers taken at launch. All three are held until the cycle of mem_done, after which mem_req drops.
- R7: Control bit0 raises mem_req with mem_we=0 and mem_addr from the address register. mem_rdata at mem_done is stored into the data register.
- R8: A control write that arrives while a memory operation or pot update is pending launches nothing. When several command bits are set at once, only one operation starts, with priority write, then read, then pot update.
- R9: Control bit2 raises pot_req. pot_drive is set to {drive high, drive low} and pot_thresh to {threshold high, threshold low}, and both are held until pot_done. Writing the setting registers alone leaves pot_drive and pot_thresh unchanged.
- R10: The sense-delay register is read back by the host and drives the sense_delay output.
- R11: If CSn rises before the eighth bit of a byte, that byte and the rest of the transaction are discarded and no register changes.
- R12: After reset all registers are 0x00, mem_req and pot_req are 0, and MISO is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI clock from host, idle low |
| csn | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host; busy flag while csn is high |
| mem_req | output | 1 | Memory operation request, held until mem_done |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 8 | Memory address latched at launch |
| mem_wdata | output | 8 | Memory write data latched at launch |
| mem_rdata | input | 8 | Memory read data, valid with mem_done |
| mem_done | input | 1 | One-cycle memory completion pulse |
| pot_req | output | 1 | Potentiometer update request, held until pot_done |
| pot_drive | output | 16 | Drive setting latched at launch |
| pot_thresh | output | 16 | Threshold setting latched at launch |
| pot_done | input | 1 | One-cycle pot update completion pulse |
| sense_delay | output | 8 | Current sense-delay register |

## Verification
Each rising SCLK edge passes through two synchronizer flops and an edge-detect register, so a received byte takes effect three to four system clocks after its eighth rising edge. The read byte is loaded into the transmitter one clock after that. The bench holds each SCLK phase for eight system clocks and samples MISO at the last falling system-clock edge before each rise, which leaves a margin of several clocks over that latency. Busy appears on MISO about three clocks after CSn rises and clears one clock after mem_done. The bench therefore checks busy ten clocks after CSn goes high and checks ready five clocks after it sees mem_req drop. Back-end outputs are compared when the back-end model observes each launch.

// File: rtl/spireg_pkg.sv
package spireg_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned SET_W  = 2 * BYTE_W;
    localparam int unsigned IDX_W  = 2;

    localparam logic [6:0] RA_ADDR = 7'h00;
    localparam logic [6:0] RA_DATA = 7'h01;
    localparam logic [6:0] RA_CTRL = 7'h02;
    localparam logic [6:0] RA_DRVH = 7'h03;
    localparam logic [6:0] RA_DRVL = 7'h04;
    localparam logic [6:0] RA_THRH = 7'h05;
    localparam logic [6:0] RA_THRL = 7'h06;
    localparam logic [6:0] RA_SDLY = 7'h07;

    localparam int unsigned CB_RD  = 0;
    localparam int unsigned CB_WR  = 1;
    localparam int unsigned CB_POT = 2;
endpackage

// File: rtl/spireg_sync.sv
module spireg_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int unsigned CHAIN_W = WIDTH * STAGES;

    logic [CHAIN_W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[CHAIN_W-WIDTH-1:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/spireg_shift.sv
module spireg_shift
    import spireg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              csn_s,
    input  logic              mosi_s,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_byte,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic [IDX_W-1:0]  rx_idx,
    output logic              miso_bit,
    output logic              cs_active
);
    localparam int unsigned CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [IDX_W-1:0] IDX_SAT  = {IDX_W{1'b1}};

    typedef struct packed {
        logic              sclk_prev;
        logic [CNT_W-1:0]  bitcnt;
        logic [BYTE_W-1:0] shreg;
        logic [BYTE_W-1:0] rx_byte;
        logic              rx_valid;
        logic [IDX_W-1:0]  rx_idx;
        logic [IDX_W-1:0]  nbyte;
        logic [BYTE_W-1:0] tx;
    } shift_t;

    shift_t d, q;

    always_comb begin
        d = q;
        d.rx_valid  = 1'b0;
        d.sclk_prev = sclk_s;
        if (csn_s) begin
            d.bitcnt = '0;
            d.nbyte  = '0;
            d.tx     = '0;
        end else begin
            if (sclk_s && !q.sclk_prev) begin
                d.shreg  = {q.shreg[BYTE_W-2:0], mosi_s};
                d.bitcnt = q.bitcnt + 1'b1;
                d.tx     = {q.tx[BYTE_W-2:0], 1'b0};
                if (q.bitcnt == LAST_BIT) begin
                    d.rx_byte  = {q.shreg[BYTE_W-2:0], mosi_s};
                    d.rx_valid = 1'b1;
                    d.rx_idx   = q.nbyte;
                    if (q.nbyte != IDX_SAT) d.nbyte = q.nbyte + 1'b1;
                end
            end
            if (load) d.tx = load_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rx_byte   = q.rx_byte;
    assign rx_valid  = q.rx_valid;
    assign rx_idx    = q.rx_idx;
    assign miso_bit  = q.tx[BYTE_W-1];
    assign cs_active = !csn_s;

    // R1
    rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R11
    cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csn_s |=> !rx_valid);
endmodule

// File: rtl/spireg_regs.sv
module spireg_regs
    import spireg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_valid,
    input  logic [IDX_W-1:0]  rx_idx,
    output logic              load,
    output logic [BYTE_W-1:0] load_byte,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [BYTE_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  logic              mem_done,
    output logic              pot_req,
    output logic [SET_W-1:0]  pot_drive,
    output logic [SET_W-1:0]  pot_thresh,
    input  logic              pot_done,
    output logic [BYTE_W-1:0] sense_delay
);
    typedef struct packed {
        logic [BYTE_W-1:0] hdr;
        logic [BYTE_W-1:0] addr;
        logic [BYTE_W-1:0] data;
        logic [BYTE_W-1:0] drvh;
        logic [BYTE_W-1:0] drvl;
        logic [BYTE_W-1:0] thrh;
        logic [BYTE_W-1:0] thrl;
        logic [BYTE_W-1:0] sdly;
        logic              mreq;
        logic              mwe;
        logic [BYTE_W-1:0] maddr;
        logic [BYTE_W-1:0] mwdata;
        logic              preq;
        logic [SET_W-1:0]  pdrv;
        logic [SET_W-1:0]  pthr;
        logic              load;
        logic [BYTE_W-1:0] load_byte;
    } regs_t;

    regs_t d, q;

    function automatic logic [BYTE_W-1:0] rd_mux(input logic [6:0] a, input regs_t s);
        case (a)
            RA_ADDR: rd_mux = s.addr;
            RA_DATA: rd_mux = s.data;
            RA_DRVH: rd_mux = s.drvh;
            RA_DRVL: rd_mux = s.drvl;
            RA_THRH: rd_mux = s.thrh;
            RA_THRL: rd_mux = s.thrl;
            RA_SDLY: rd_mux = s.sdly;
            default: rd_mux = '0;
        endcase
    endfunction

    logic hdr_byte, val_byte, idle;

    always_comb begin
        hdr_byte = rx_valid && (rx_idx == IDX_W'(0));
        val_byte = rx_valid && (rx_idx == IDX_W'(1)) && q.hdr[BYTE_W-1];
        idle     = !q.mreq && !q.preq;
        d = q;
        d.load = 1'b0;
        if (hdr_byte) begin
            d.hdr = rx_byte;
            if (!rx_byte[BYTE_W-1]) begin
                d.load      = 1'b1;
                d.load_byte = rd_mux(rx_byte[6:0], q);
            end
        end
        if (q.mreq && mem_done) begin
            d.mreq = 1'b0;
            if (!q.mwe) d.data = mem_rdata;
        end
        if (q.preq && pot_done) d.preq = 1'b0;
        if (val_byte) begin
            case (q.hdr[6:0])
                RA_ADDR: d.addr = rx_byte;
                RA_DATA: d.data = rx_byte;
                RA_DRVH: d.drvh = rx_byte;
                RA_DRVL: d.drvl = rx_byte;
                RA_THRH: d.thrh = rx_byte;
                RA_THRL: d.thrl = rx_byte;
                RA_SDLY: d.sdly = rx_byte;
                RA_CTRL: begin
                    if (idle) begin
                        if (rx_byte[CB_WR]) begin
                            d.mreq   = 1'b1;
                            d.mwe    = 1'b1;
                            d.maddr  = q.addr;
                            d.mwdata = q.data;
                        end else if (rx_byte[CB_RD]) begin
                            d.mreq  = 1'b1;
                            d.mwe   = 1'b0;
                            d.maddr = q.addr;
                        end else if (rx_byte[CB_POT]) begin
                            d.preq = 1'b1;
                            d.pdrv = {q.drvh, q.drvl};
                            d.pthr = {q.thrh, q.thrl};
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign load        = q.load;
    assign load_byte   = q.load_byte;
    assign busy        = q.mreq;
    assign mem_req     = q.mreq;
    assign mem_we      = q.mwe;
    assign mem_addr    = q.maddr;
    assign mem_wdata   = q.mwdata;
    assign pot_req     = q.preq;
    assign pot_drive   = q.pdrv;
    assign pot_thresh  = q.pthr;
    assign sense_delay = q.sdly;

    // R6
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_done) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

    // R7
    rd_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_done) |=> (q.data == $past(mem_rdata)));

    // R8
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> $past(!pot_req));

    // R9
    pot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pot_req && !pot_done) |=> (pot_req && $stable(pot_drive) && $stable(pot_thresh)));
endmodule

// File: rtl/spireg_slave.sv
module spireg_slave
    import spireg_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              csn,
    input  logic              mosi,
    output logic              miso,
    output logic              mem_req,
    output logic              mem_we,
    output logic [BYTE_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  logic              mem_done,
    output logic              pot_req,
    output logic [SET_W-1:0]  pot_drive,
    output logic [SET_W-1:0]  pot_thresh,
    input  logic              pot_done,
    output logic [BYTE_W-1:0] sense_delay
);
    logic              csn_s, sclk_s, mosi_s;
    logic              load, rx_valid, miso_bit, cs_active, busy;
    logic [BYTE_W-1:0] load_byte, rx_byte;
    logic [IDX_W-1:0]  rx_idx;

    spireg_sync #(
        .WIDTH(3),
        .STAGES(SYNC_STAGES),
        .RESET_VAL(3'b100)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({csn, sclk, mosi}),
        .dout ({csn_s, sclk_s, mosi_s})
    );

    spireg_shift u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_s   (sclk_s),
        .csn_s    (csn_s),
        .mosi_s   (mosi_s),
        .load     (load),
        .load_byte(load_byte),
        .rx_byte  (rx_byte),
        .rx_valid (rx_valid),
        .rx_idx   (rx_idx),
        .miso_bit (miso_bit),
        .cs_active(cs_active)
    );

    spireg_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_byte    (rx_byte),
        .rx_valid   (rx_valid),
        .rx_idx     (rx_idx),
        .load       (load),
        .load_byte  (load_byte),
        .busy       (busy),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .mem_done   (mem_done),
        .pot_req    (pot_req),
        .pot_drive  (pot_drive),
        .pot_thresh (pot_thresh),
        .pot_done   (pot_done),
        .sense_delay(sense_delay)
    );

    assign miso = cs_active ? miso_bit : busy;

    // R5
    busy_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csn_s && !mem_req) |-> !miso);
endmodule

// File: tb/sim_spireg_slave.sv
module sim_spireg_slave;
    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0, csn = 1'b1, mosi = 1'b0;
    logic        miso;
    logic        mem_req, mem_we, pot_req;
    logic [7:0]  mem_addr, mem_wdata, sense_delay;
    logic [7:0]  mem_rdata = 8'h00;
    logic        mem_done = 1'b0, pot_done = 1'b0;
    logic [15:0] pot_drive, pot_thresh;

    int checks = 0, errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    spireg_slave u0 (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .csn(csn), .mosi(mosi), .miso(miso),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_done(mem_done), .pot_req(pot_req),
        .pot_drive(pot_drive), .pot_thresh(pot_thresh), .pot_done(pot_done),
        .sense_delay(sense_delay)
    );

    // back-end models
    logic [7:0]  mem_model [256];
    int          mem_delay = 10, pot_delay = 10;
    int          mcnt = 0, pcnt = 0, mem_launches = 0, pot_launches = 0;
    bit          m_active = 0, p_active = 0;
    logic        seen_we;
    logic [7:0]  seen_addr, seen_wdata;
    logic [15:0] seen_drv, seen_thr;

    always @(negedge clk) begin
        if (mem_done) mem_done = 1'b0;
        else if (mem_req) begin
            if (!m_active) begin
                m_active = 1; mcnt = mem_delay; mem_launches++;
                seen_we = mem_we; seen_addr = mem_addr; seen_wdata = mem_wdata;
            end else if (mcnt > 0) mcnt--;
            else begin
                m_active = 0; mem_done = 1'b1;
                if (mem_we) mem_model[mem_addr] = mem_wdata;
                else        mem_rdata = mem_model[mem_addr];
            end
        end
        if (pot_done) pot_done = 1'b0;
        else if (pot_req) begin
            if (!p_active) begin
                p_active = 1; pcnt = pot_delay; pot_launches++;
                seen_drv = pot_drive; seen_thr = pot_thresh;
            end else if (pcnt > 0) pcnt--;
            else begin p_active = 0; pot_done = 1'b1; end
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = 8'h00;
        for (int i = 7; i > 7 - nbits; i--) begin
            mosi = tx[i];
            wait_clk(HALF);
            rx[i] = miso;
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
        end
    endtask

    task automatic cs_lo();
        csn = 1'b0; wait_clk(HALF);
    endtask

    task automatic cs_hi();
        wait_clk(HALF); csn = 1'b1; wait_clk(HALF);
    endtask

    task automatic spi_wr(input logic [6:0] a, input logic [7:0] v);
        logic [7:0] r;
        cs_lo();
        xfer_bits({1'b1, a}, 8, r);
        xfer_bits(v, 8, r);
        cs_hi();
    endtask

    task automatic spi_rd(input logic [6:0] a, output logic [7:0] v);
        logic [7:0] r;
        cs_lo();
        xfer_bits({1'b0, a}, 8, r);
        xfer_bits(8'h00, 8, v);
        cs_hi();
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 6000 && mem_req; i++) wait_clk(1);
        wait_clk(5);
    endtask

    function automatic logic [6:0] pick_mapped(input int r);
        logic [6:0] m [7] = '{7'h0, 7'h1, 7'h3, 7'h4, 7'h5, 7'h6, 7'h7};
        return m[r % 7];
    endfunction

    logic [7:0] shadow [8];

    initial begin
        logic [7:0] v, rb;
        logic [6:0] a;
        int base, pbase;
        void'($urandom(32'h5eed1234));
        for (int i = 0; i < 256; i++) mem_model[i] = 8'($urandom);
        for (int i = 0; i < 8; i++) shadow[i] = 8'h00;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);

        // R12 reset state
        chk(miso == 1'b0, "R12 miso", miso, 0);
        chk(mem_req == 1'b0 && pot_req == 1'b0, "R12 req", {mem_req, pot_req}, 0);
        chk(sense_delay == 8'h00, "R12 sense_delay", sense_delay, 0);
        for (int i = 0; i < 8; i++) begin
            spi_rd(7'(i), rb);
            chk(rb == 8'h00, "R12 reg reset", rb, 0);
        end

        // R1 R2 R4 R10 random write then readback
        for (int n = 0; n < 24; n++) begin
            a = pick_mapped(int'($urandom));
            v = 8'($urandom);
            spi_wr(a, v);
            shadow[a] = v;
            a = pick_mapped(int'($urandom));
            spi_rd(a, rb);
            chk(rb == shadow[a], "R1 R4 readback", rb, shadow[a]);
        end
        spi_rd(7'h07, rb);
        chk(rb == shadow[7], "R10 sense readback", rb, shadow[7]);
        chk(sense_delay == shadow[7], "R10 sense pin", sense_delay, shadow[7]);

        // R3 unmapped and control read as zero
        for (int n = 0; n < 4; n++) begin
            a = 7'(8 + ($urandom % 120));
            spi_wr(a, 8'hA5);
            spi_rd(a, rb);
            chk(rb == 8'h00, "R3 unmapped", rb, 0);
        end
        spi_wr(7'h02, 8'h00);
        spi_rd(7'h02, rb);
        chk(rb == 8'h00, "R3 ctrl read", rb, 0);

        // R2 extra bytes ignored
        cs_lo();
        xfer_bits(8'h87, 8, rb);
        xfer_bits(8'h3C, 8, rb);
        xfer_bits(8'hC3, 8, rb);
        cs_hi();
        shadow[7] = 8'h3C;
        spi_rd(7'h07, rb);
        chk(rb == 8'h3C, "R2 third byte ignored", rb, 8'h3C);

        // R11 aborted mid-byte
        cs_lo();
        xfer_bits(8'h87, 8, rb);
        xfer_bits(8'hFF, 4, rb);
        cs_hi();
        spi_rd(7'h07, rb);
        chk(rb == 8'h3C, "R11 abort value", rb, 8'h3C);
        cs_lo();
        xfer_bits(8'h83, 5, rb);
        cs_hi();
        spi_wr(7'h05, 8'h11);
        spi_rd(7'h05, rb);
        chk(rb == 8'h11, "R11 recovery", rb, 8'h11);
        shadow[5] = 8'h11;

        // R6 R5 memory write with long latency, R8 command while busy
        spi_wr(7'h00, 8'h5A); spi_wr(7'h01, 8'hC7);
        mem_delay = 2000;
        base = mem_launches;
        spi_wr(7'h02, 8'h02);
        wait_clk(10);
        chk(miso == 1'b1, "R5 busy high", miso, 1);
        chk(mem_req && seen_we == 1'b1, "R6 write launch", {mem_req, seen_we}, 2'b11);
        chk(seen_addr == 8'h5A && seen_wdata == 8'hC7, "R6 addr/data", {seen_addr, seen_wdata}, 16'h5AC7);
        spi_wr(7'h01, 8'h99);
        spi_wr(7'h02, 8'h01);
        chk(mem_addr == 8'h5A && mem_wdata == 8'hC7, "R6 held", {mem_addr, mem_wdata}, 16'h5AC7);
        wait_ready();
        chk(miso == 1'b0, "R5 ready low", miso, 0);
        chk(mem_model[8'h5A] == 8'hC7, "R6 stored", mem_model[8'h5A], 8'hC7);
        chk(mem_launches == base + 1 && !mem_req, "R8 ignored while busy", mem_launches - base, 1);

        // R7 memory reads with random latency
        for (int n = 0; n < 5; n++) begin
            v = 8'($urandom);
            mem_delay = 5 + int'($urandom % 60);
            spi_wr(7'h00, v);
            spi_wr(7'h02, 8'h01);
            wait_ready();
            chk(seen_we == 1'b0 && seen_addr == v, "R7 read launch", {seen_we, seen_addr}, {1'b0, v});
            spi_rd(7'h01, rb);
            chk(rb == mem_model[v], "R7 read data", rb, mem_model[v]);
        end

        // R8 priority with all bits set
        mem_delay = 20;
        spi_wr(7'h00, 8'h21); spi_wr(7'h01, 8'h6E);
        base = mem_launches; pbase = pot_launches;
        spi_wr(7'h02, 8'h07);
        wait_ready();
        chk(mem_launches == base + 1 && seen_we == 1'b1, "R8 write priority", seen_we, 1);
        chk(pot_launches == pbase, "R8 no pot", pot_launches - pbase, 0);
        chk(mem_model[8'h21] == 8'h6E, "R8 write done", mem_model[8'h21], 8'h6E);

        // R9 pot update
        spi_wr(7'h03, 8'hAB); spi_wr(7'h04, 8'hCD);
        spi_wr(7'h05, 8'h12); spi_wr(7'h06, 8'h34);
        chk(pot_drive == 16'h0000 && !pot_req, "R9 no update before cmd", pot_drive, 0);
        pot_delay = 2000;
        pbase = pot_launches; base = mem_launches;
        spi_wr(7'h02, 8'h04);
        wait_clk(10);
        chk(pot_req && seen_drv == 16'hABCD && seen_thr == 16'h1234, "R9 pot values", {seen_drv, seen_thr}, 32'hABCD1234);
        chk(miso == 1'b0, "R5 pot not busy", miso, 0);
        spi_wr(7'h03, 8'h00);
        spi_wr(7'h02, 8'h02);
        chk(pot_drive == 16'hABCD && mem_launches == base, "R8 R9 held, cmd ignored", pot_drive, 16'hABCD);
        for (int i = 0; i < 6000 && pot_req; i++) wait_clk(1);
        wait_clk(5);
        chk(!pot_req && pot_launches == pbase + 1, "R9 pot done", pot_launches - pbase, 1);

        summary();
    end
endmodule